// File: doc/BRIEF.md
# Per-Processor Timer and Inter-Processor Interrupt Register

This block is a 64-bit control register for a small multiprocessor. It tracks a pending timer interrupt and inter-processor interrupt (IPI) state for up to four processors. It drives one timer interrupt line and one IPI line for each processor.

A periodic `tick` input posts a timer interrupt to every processor that does not already have one pending. Software acknowledges a timer interrupt, raises an IPI or acknowledges an IPI by writing 1s into bit fields of the register. Fields left at 0 in a write have no effect.

IPIs are counted rather than latched. Each processor has a saturating pending counter, and its IPI line stays high until it has received as many acknowledges as sends. A read returns the status flags with the ID of the reading processor placed in the two lowest bits. Write effects appear one clock after the write. Reads are combinational.

Top module: `ipi_timer_ctl`

## Requirements
- R1: `rd_data` has bits 1:0 equal to `acc_id`, bit 4+i equal to processor i's timer flag, and bit 8+i equal to processor i's IPI flag. All other bits read 0.
- R2: A cycle with `tick` high sets the timer flag and `timer_irq` of every processor on the next cycle. A processor that is already pending stays pending.
- R3: A write with bit 4+i set clears processor i's timer flag and `timer_irq[i]` on the next cycle, unless `tick` is high in the same cycle, in which case `tick` wins.
- R4: A write with bit 12+i set sets IPI flag i, increments processor i's pending count and holds `ipi_irq[i]` high from the next cycle.
- R5: A write with bit 8+i set clears IPI flag i and decrements a non-zero pending count. `ipi_irq[i]` is high exactly while the count is non-zero.
- R6: The pending count saturates at 2^CNT_W-1. Further sends do not wrap it.
- R7: A single write applies the fields in this order: timer acknowledge, then IPI send, then IPI acknowledge. Sending and acknowledging processor i in one write therefore leaves flag i clear and the count unchanged, or one below the maximum if the count was saturated.
- R8: `wr_unsup` pulses for one cycle after a write that has none of bits 15:4 and does not have bit 28 set. A write with only bit 28 set changes no state and raises no pulse.
- R9: After reset, all flags, counts, `timer_irq`, `ipi_irq` and `wr_unsup` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Periodic timer event |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Write data (bit fields) |
| acc_id | input | 2 | ID of the accessing processor |
| rd_data | output | 64 | Register read value |
| timer_irq | output | NCPU | Per-processor timer interrupt |
| ipi_irq | output | NCPU | Per-processor IPI line |
| wr_unsup | output | 1 | One-cycle pulse after an unrecognized write |

## Verification
The bench builds the block with NCPU=4, so every field bit of the register is in use, and with CNT_W=3, so a pending count saturates at 7. This brings counter saturation, the drain back to zero and the saturated send-plus-acknowledge case within reach of a few writes. Random writes with sparse field masks mix sends and acknowledges for several processors in the same write and collide them with ticks.

// File: rtl/ipi_timer_ctl.sv
module ipi_timer_ctl #(
  parameter int NCPU  = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [63:0]      wr_data,
  input  logic [1:0]       acc_id,
  output logic [63:0]      rd_data,
  output logic [NCPU-1:0]  timer_irq,
  output logic [NCPU-1:0]  ipi_irq,
  output logic             wr_unsup
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NCPU-1:0] tmr_pend, ipi_flag;
  logic [3:0]      tmr4, ipi4;

  wire unused_wr = ^{wr_data[63:29], wr_data[27:16], wr_data[3:0]};

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic [CNT_W-1:0] cnt, cnt_inc;
    wire snd = wr_en & wr_data[12+i];
    wire ack = wr_en & wr_data[8+i];

    assign cnt_inc = (snd && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tmr_pend[i] <= 1'b0;
        ipi_flag[i] <= 1'b0;
        cnt         <= '0;
      end else begin
        if (tick)                        tmr_pend[i] <= 1'b1;
        else if (wr_en && wr_data[4+i])  tmr_pend[i] <= 1'b0;
        if (ack)                         ipi_flag[i] <= 1'b0;
        else if (snd)                    ipi_flag[i] <= 1'b1;
        cnt <= (ack && cnt_inc != '0) ? cnt_inc - 1'b1 : cnt_inc;
      end
    end

    assign ipi_irq[i] = (cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wr_unsup <= 1'b0;
    else        wr_unsup <= wr_en && (wr_data[15:4] == '0) && !wr_data[28];
  end

  always_comb begin
    tmr4 = '0;
    ipi4 = '0;
    tmr4[NCPU-1:0] = tmr_pend;
    ipi4[NCPU-1:0] = ipi_flag;
  end

  assign timer_irq = tmr_pend;
  assign rd_data   = {52'd0, ipi4, tmr4, 2'b00, acc_id};
endmodule

// File: rtl/ipi_timer_ctl_chk.sv
module ipi_timer_ctl_chk #(
  parameter int NCPU = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            wr_en,
  input logic [63:0]     wr_data,
  input logic [63:0]     rd_data,
  input logic [NCPU-1:0] timer_irq,
  input logic [NCPU-1:0] ipi_irq,
  input logic            wr_unsup
);
  // R1
  rd_flags_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4 +: NCPU] == timer_irq);

  // R2
  tick_posts_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> timer_irq == {NCPU{1'b1}});

  // R3
  timer_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4] && !tick) |=> !timer_irq[0]);

  // R4
  ipi_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[12] && !wr_data[8]) |=> ipi_irq[0] && rd_data[8]);

  // R5
  ipi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_irq[0] && !(wr_en && wr_data[8])) |=> ipi_irq[0]);

  // R8
  unsup_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:4] == 12'd0 && !wr_data[28]) |=> wr_unsup);

  // R8
  unsup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !wr_unsup);
endmodule

bind ipi_timer_ctl ipi_timer_ctl_chk #(.NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .timer_irq(timer_irq), .ipi_irq(ipi_irq),
  .wr_unsup(wr_unsup)
);

// File: tb/test_ipi_timer_ctl.sv
`timescale 1ns/1ps
module test_ipi_timer_ctl;
  localparam int NCPU = 4;
  localparam int CNT_W = 3;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, wr_unsup;
  logic [63:0] wr_data = '0, rd_data;
  logic [1:0] acc_id = '0;
  logic [NCPU-1:0] timer_irq, ipi_irq;

  int n_chk = 0, n_fail = 0;
  bit mt[NCPU], mf[NCPU];
  int mc[NCPU];
  bit m_uns;

  always #2 clk = ~clk;

  ipi_timer_ctl #(.NCPU(NCPU), .CNT_W(CNT_W)) i_ipi_timer_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .acc_id(acc_id), .rd_data(rd_data), .timer_irq(timer_irq),
    .ipi_irq(ipi_irq), .wr_unsup(wr_unsup));

  function automatic logic [63:0] exp_rd(logic [1:0] id);
    logic [63:0] v = {62'd0, id};
    for (int i = 0; i < NCPU; i++) begin
      v[4+i] = mt[i];
      v[8+i] = mf[i];
    end
    return v;
  endfunction

  function automatic logic [NCPU-1:0] exp_tmr();
    logic [NCPU-1:0] v;
    for (int i = 0; i < NCPU; i++) v[i] = mt[i];
    return v;
  endfunction

  function automatic logic [NCPU-1:0] exp_ipi();
    logic [NCPU-1:0] v;
    for (int i = 0; i < NCPU; i++) v[i] = (mc[i] != 0);
    return v;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    check("R1 read-back", rd_data, exp_rd(acc_id));
    check("R2/R3 timer_irq", 64'(timer_irq), 64'(exp_tmr()));
    check("R4/R5 ipi_irq", 64'(ipi_irq), 64'(exp_ipi()));
    check("R8 wr_unsup", 64'(wr_unsup), 64'(m_uns));
  endtask

  task automatic step(bit tk, bit we, logic [63:0] d, logic [1:0] id);
    @(negedge clk);
    tick = tk; wr_en = we; wr_data = d; acc_id = id;
    for (int i = 0; i < NCPU; i++) begin
      if (tk) mt[i] = 1;
      else if (we && d[4+i]) mt[i] = 0;
      if (we && d[8+i]) mf[i] = 0;
      else if (we && d[12+i]) mf[i] = 1;
      if (we && d[12+i] && mc[i] < MAXC) mc[i]++;
      if (we && d[8+i] && mc[i] > 0) mc[i]--;
    end
    m_uns = we && d[15:4] == 12'd0 && !d[28];
    @(posedge clk); #1;
    check_all();
    tick = 0; wr_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < NCPU; i++) begin mt[i] = 0; mf[i] = 0; mc[i] = 0; end
    m_uns = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R9 reset state
    check("R9 reset rd_data", rd_data, 64'd0);
    check("R9 reset timer_irq", 64'(timer_irq), 64'd0);
    check("R9 reset ipi_irq", 64'(ipi_irq), 64'd0);
    check("R9 reset wr_unsup", 64'(wr_unsup), 64'd0);

    // R2 tick posts to all, R3 ack of one
    step(1, 0, 64'd0, 2'd3);
    step(0, 1, 64'h20, 2'd1);
    check("R3 cpu1 cleared", 64'(timer_irq), 64'hD);
    // R3 tick wins over ack
    step(1, 1, 64'h10, 2'd0);
    check("R3 tick wins", 64'(timer_irq), 64'hF);

    // R6 saturation on cpu2
    for (int k = 0; k < MAXC + 3; k++) step(0, 1, 64'h4000, 2'd2);
    check("R6 flag set", 64'(rd_data[10]), 64'd1);
    // R5 drain: line stays high until count reaches zero
    for (int k = 0; k < MAXC - 1; k++) step(0, 1, 64'h400, 2'd2);
    check("R5 still pending", 64'(ipi_irq[2]), 64'd1);
    check("R5 flag cleared", 64'(rd_data[10]), 64'd0);
    step(0, 1, 64'h400, 2'd2);
    check("R5 drained", 64'(ipi_irq[2]), 64'd0);

    // R7 send and ack in one write
    step(0, 1, 64'h2000, 2'd0);
    step(0, 1, 64'h2200, 2'd0);
    check("R7 flag clear", 64'(rd_data[9]), 64'd0);
    check("R7 count kept", 64'(ipi_irq[1]), 64'd1);

    // R8 unsupported and bit 28
    step(0, 1, 64'h0000_0000_0000_000F, 2'd1);
    check("R8 pulse", 64'(wr_unsup), 64'd1);
    step(0, 1, 64'h0000_0000_1000_0000, 2'd2);
    check("R8 bit28 quiet", 64'(wr_unsup), 64'd0);

    for (int k = 0; k < 3000; k++) begin
      logic [63:0] d = {$urandom, $urandom};
      int sel = $urandom_range(0, 9);
      logic [15:0] f = 16'($urandom) & 16'($urandom) & 16'hFFF0;
      d[15:0] = (sel < 2) ? 16'd0 : f;
      d[28] = (sel == 0);
      step($urandom_range(0, 7) == 0, $urandom_range(0, 2) != 0, d,
           2'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule